// File: doc/BRIEF.md
# Single-Channel Peripheral DMA Engine

This block is one DMA channel. A 32-bit register port configures it, and a simple memory port lets it move data on its own. Software writes a source address, a destination address and a byte count. It then writes the control word with its start bit set. From then on the engine repeats read-then-write beats until the count is used up. Each side has its own element width, its own burst length and its own option to hold the address fixed, so either end can be a peripheral FIFO.

Each side has a request input that gates the start of its bursts. A log2 wait-state field spaces the beats apart. A continuous mode reloads the programmed transfer each time it completes. Two one-cycle outputs mark the half-way point and the end of each pass. The same control bit starts a transfer, reads back as busy, and halts the transfer when it is written to zero.

Top module: `pdma_channel`

## Requirements
- R1: Registers are word-aligned at byte offset 0x0 (control), 0x4 (source address), 0x8 (destination address) and 0xC (byte count). A write is decoded only when address bits 1:0 are zero. After reset all four registers read as zero.
- R2: Control fields:
  - bit 30: continuous mode
  - bits 29:27: wait log2
  - bits 26:25: destination width
  - bits 24:23: destination burst
  - bit 21: destination fixed
  - bits 20:16: destination request select
  - bits 10:9: source width
  - bits 8:7: source burst
  - bit 5: source fixed
  - bits 4:0: source request select

  All other bits below 31 read as zero.
- R3: The byte count register keeps 18 bits, so writing all ones reads back as 0x3FFFF.
- R4: Writing control with bit 31 set while idle and with a nonzero count starts a transfer. Bit 31 then reads as 1 until the transfer ends. With a zero count, the start is ignored.
- R5: Writing control with bit 31 clear while busy halts the channel at once. No further memory request, write or pulse follows, and bit 31 reads 0.
- R6: While busy, writes to the address and count registers are ignored, and a control write with bit 31 set changes no field.
- R7: Each beat reads one source element and then writes the read word to the destination. Width codes are 0 for 1 byte, 1 for 2 bytes and 2 for 4 bytes, and mem_size carries the width code. The count falls by the destination width, or by the remainder if that is smaller. Each address steps by its own side's width.
- R8: A side whose fixed bit is set presents the same programmed address on every beat.
- R9: Burst codes are 0 for 1 beat, 1 for 4 beats and 2 for 8 beats. A side starts a new burst only while its request input is high, and finishes the burst's remaining beats without the request.
- R10: With wait code w, the next read is accepted 2^w cycles after the previous write is accepted, so code 0 is back to back.
- R11: The end pulse is high for the one cycle after the final write is accepted. Bit 31 then reads 0, unless continuous mode is set. In continuous mode the addresses and count reload and the transfer restarts.
- R12: The half pulse is high for one cycle, after the first write that leaves the remaining count at or below half the programmed count (rounded down). It fires once per pass.
- R13: The reserved width and burst code 3 behaves as code 0, and mem_size never shows 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| src_req | input | 1 | Source side request, gates source bursts |
| dst_req | input | 1 | Destination side request, gates destination bursts |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | 32 | Memory byte address |
| mem_size | output | 2 | Access width code |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access accepted this cycle; read data valid with it |
| mem_rdata | input | 32 | Read data |
| xfer_half | output | 1 | Half-transfer pulse |
| xfer_done | output | 1 | End-of-transfer pulse |

## Verification
A wrong remaining count or half-way flag appears as a pulse placed one write early or late. That pulse is caught in the cycle after the write that should have produced it. A wrong address step or a fixed-address slip corrupts the address or data of the very next write, and the scoreboard compares every write as it is accepted. A burst counter or wait counter that drifts shows up as a read gap or a read total that differs from what the request timing allows, within a few cycles of the faulty beat. A busy state that outlives a halt shows up as a memory request after the halt write.

// File: rtl/pdma_pkg.sv
// Shared definitions for the single-channel DMA engine: control bit
// positions, the state encoding and the code decoders.
// Assumes a 32-bit register port.
package pdma_pkg;
    localparam int DW     = 32;
    localparam int REG_AW = 4;

    localparam int B_START = 31;
    localparam int B_CONT  = 30;
    localparam int B_WAIT  = 27;
    localparam int B_DW    = 25;
    localparam int B_DB    = 23;
    localparam int B_DFIX  = 21;
    localparam int B_DSEL  = 16;
    localparam int B_SW    = 9;
    localparam int B_SB    = 7;
    localparam int B_SFIX  = 5;
    localparam int B_SSEL  = 0;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_WAIT  = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic       cont;
        logic [2:0] wait_log2;
        logic [1:0] dst_width;
        logic [1:0] dst_burst;
        logic       dst_fixed;
        logic [4:0] dst_sel;
        logic [1:0] src_width;
        logic [1:0] src_burst;
        logic       src_fixed;
        logic [4:0] src_sel;
    } ctl_t;

    // Unpack a control word into its fields.
    function automatic ctl_t word_to_ctl(input logic [DW-1:0] w);
        ctl_t c;
        c.cont      = w[B_CONT];
        c.wait_log2 = w[B_WAIT +: 3];
        c.dst_width = w[B_DW +: 2];
        c.dst_burst = w[B_DB +: 2];
        c.dst_fixed = w[B_DFIX];
        c.dst_sel   = w[B_DSEL +: 5];
        c.src_width = w[B_SW +: 2];
        c.src_burst = w[B_SB +: 2];
        c.src_fixed = w[B_SFIX];
        c.src_sel   = w[B_SSEL +: 5];
        return c;
    endfunction

    // Pack the fields and the busy flag back into a control word.
    function automatic logic [DW-1:0] ctl_to_word(input ctl_t c, input logic busy);
        logic [DW-1:0] w;
        w = '0;
        w[B_START]      = busy;
        w[B_CONT]       = c.cont;
        w[B_WAIT +: 3]  = c.wait_log2;
        w[B_DW +: 2]    = c.dst_width;
        w[B_DB +: 2]    = c.dst_burst;
        w[B_DFIX]       = c.dst_fixed;
        w[B_DSEL +: 5]  = c.dst_sel;
        w[B_SW +: 2]    = c.src_width;
        w[B_SB +: 2]    = c.src_burst;
        w[B_SFIX]       = c.src_fixed;
        w[B_SSEL +: 5]  = c.src_sel;
        return w;
    endfunction

    // The reserved code 3 folds onto code 0.
    function automatic logic [1:0] clean_code(input logic [1:0] code);
        return (code == 2'd3) ? 2'd0 : code;
    endfunction

    // Element width code to a byte count.
    function automatic logic [2:0] width_bytes(input logic [1:0] code);
        case (code)
            2'd1:    return 3'd2;
            2'd2:    return 3'd4;
            default: return 3'd1;
        endcase
    endfunction

    // Burst code to a beat count.
    function automatic logic [3:0] burst_beats(input logic [1:0] code);
        case (code)
            2'd1:    return 4'd4;
            2'd2:    return 4'd8;
            default: return 4'd1;
        endcase
    endfunction
endpackage

// File: rtl/pdma_regfile.sv
// Register file of the DMA channel: it holds the control fields, the two
// programmed addresses and the programmed count. It turns control writes
// into start and halt strobes. Assumes the sequencer's busy flag reflects
// the state it entered on the previous edge.
module pdma_regfile
    import pdma_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [REG_AW-1:0] addr,
    input  logic [DW-1:0]     wdata,
    input  logic              busy,
    output logic [DW-1:0]     rdata,
    output ctl_t              ctl,
    output logic [AW-1:0]     src_base,
    output logic [AW-1:0]     dst_base,
    output logic [CW-1:0]     count_base,
    output logic              start,
    output logic              halt
);
    logic       aligned;
    logic [1:0] idx;
    logic       wr_ctl, wr_src, wr_dst, wr_cnt;
    logic       unused_wbits;

    assign aligned = (addr[1:0] == 2'b00);
    assign idx     = addr[3:2];
    assign wr_ctl  = wr && aligned && (idx == 2'd0);
    assign wr_src  = wr && aligned && (idx == 2'd1);
    assign wr_dst  = wr && aligned && (idx == 2'd2);
    assign wr_cnt  = wr && aligned && (idx == 2'd3);

    assign start = wr_ctl && wdata[B_START] && !busy && (count_base != '0);
    assign halt  = wr_ctl && !wdata[B_START] && busy;

    assign unused_wbits = ^{wdata[22], wdata[15:11], wdata[6]};

    // Store the fields; every register is frozen while a transfer runs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl        <= '0;
            src_base   <= '0;
            dst_base   <= '0;
            count_base <= '0;
        end else if (!busy) begin
            if (wr_ctl) ctl        <= word_to_ctl(wdata);
            if (wr_src) src_base   <= wdata[AW-1:0];
            if (wr_dst) dst_base   <= wdata[AW-1:0];
            if (wr_cnt) count_base <= wdata[CW-1:0];
        end
    end

    // Read multiplexer, zero-extending the narrow registers.
    always_comb begin
        rdata = '0;
        case (idx)
            2'd0:    rdata = ctl_to_word(ctl, busy);
            2'd1:    rdata[AW-1:0] = src_base;
            2'd2:    rdata[AW-1:0] = dst_base;
            default: rdata[CW-1:0] = count_base;
        endcase
    end
endmodule

// File: rtl/pdma_addr_gen.sv
// Working address for one side of the channel. It loads the programmed
// base and advances by the side's element width after each accepted
// access, unless the side is fixed. A load wins over a step in the same cycle.
module pdma_addr_gen
    import pdma_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic          fixed,
    input  logic [1:0]    width_code,
    input  logic [AW-1:0] base,
    output logic [AW-1:0] addr
);
    // Hold, reload or advance the working address.
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr <= '0;
        else if (load)
            addr <= base;
        else if (step && !fixed)
            addr <= addr + AW'(width_bytes(width_code));
    end
endmodule

// File: rtl/pdma_seq.sv
// Transfer sequencer: read beat, write beat, optional wait. It keeps the
// remaining count, a beat counter per side for bursts, the wait counter
// and the two pulses. Assumes memory read data is valid in the cycle that
// mem_ack accepts the read.
module pdma_seq
    import pdma_pkg::*;
#(
    parameter int CW  = 18,
    parameter int WCW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          halt,
    input  logic          cont,
    input  logic [2:0]    wait_log2,
    input  logic [1:0]    dst_width,
    input  logic [1:0]    src_burst,
    input  logic [1:0]    dst_burst,
    input  logic [CW-1:0] count_base,
    input  logic          src_req,
    input  logic          dst_req,
    input  logic          mem_ack,
    input  logic [DW-1:0] mem_rdata,
    output logic          busy,
    output logic          rd_req,
    output logic          wr_req,
    output logic          addr_load,
    output logic          src_step,
    output logic          dst_step,
    output logic [DW-1:0] data_q,
    output logic          xfer_half,
    output logic          xfer_done
);
    seq_state_e     state;
    logic [CW-1:0]  rem, dbytes, dec, rem_next;
    logic [3:0]     src_left, dst_left;
    logic [WCW-1:0] wait_cnt, wait_len;
    logic           half_done, rd_fire, wr_fire, last, half_hit;

    assign busy     = (state != ST_IDLE);
    assign rd_req   = (state == ST_READ)  && ((src_left != 4'd0) || src_req);
    assign wr_req   = (state == ST_WRITE) && ((dst_left != 4'd0) || dst_req);
    assign rd_fire  = rd_req && mem_ack;
    assign wr_fire  = wr_req && mem_ack;
    assign src_step = rd_fire;
    assign dst_step = wr_fire;

    // Remaining-count arithmetic for the current write beat.
    always_comb begin
        dbytes   = CW'(width_bytes(dst_width));
        dec      = (rem < dbytes) ? rem : dbytes;
        rem_next = rem - dec;
        last     = wr_fire && (rem_next == '0);
        half_hit = wr_fire && !half_done && (rem_next <= (count_base >> 1));
        wait_len = WCW'((8'd1 << wait_log2) - 8'd1);
    end

    assign addr_load = start || (last && cont && !halt);

    // Main sequencer with beat, burst and wait bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            rem       <= '0;
            src_left  <= '0;
            dst_left  <= '0;
            wait_cnt  <= '0;
            half_done <= 1'b0;
            data_q    <= '0;
            xfer_half <= 1'b0;
            xfer_done <= 1'b0;
        end else begin
            xfer_half <= half_hit && !halt;
            xfer_done <= last && !halt;
            if (halt) begin
                state <= ST_IDLE;
            end else begin
                case (state)
                    ST_IDLE: if (start) begin
                        state     <= ST_READ;
                        rem       <= count_base;
                        src_left  <= '0;
                        dst_left  <= '0;
                        half_done <= 1'b0;
                    end
                    ST_READ: if (rd_fire) begin
                        data_q   <= mem_rdata;
                        src_left <= (src_left != 4'd0) ? src_left - 4'd1
                                                       : burst_beats(src_burst) - 4'd1;
                        state    <= ST_WRITE;
                    end
                    ST_WRITE: if (wr_fire) begin
                        dst_left <= (dst_left != 4'd0) ? dst_left - 4'd1
                                                       : burst_beats(dst_burst) - 4'd1;
                        wait_cnt <= wait_len;
                        if (half_hit) half_done <= 1'b1;
                        if (last && !cont) begin
                            state <= ST_IDLE;
                            rem   <= '0;
                        end else begin
                            if (last) begin
                                rem       <= count_base;
                                half_done <= 1'b0;
                            end else begin
                                rem <= rem_next;
                            end
                            state <= (wait_log2 != 3'd0) ? ST_WAIT : ST_READ;
                        end
                    end
                    ST_WAIT: begin
                        if (wait_cnt <= WCW'(1)) state <= ST_READ;
                        else wait_cnt <= wait_cnt - WCW'(1);
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/pdma_channel.sv
// Top of the single-channel DMA engine. It ties the register file, the
// sequencer and one address generator per side onto the memory port.
// Assumes the requester keeps mem_req's inputs stable across a cycle.
module pdma_channel
    import pdma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    input  logic              src_req,
    input  logic              dst_req,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [1:0]        mem_size,
    output logic [DW-1:0]     mem_wdata,
    input  logic              mem_ack,
    input  logic [DW-1:0]     mem_rdata,
    output logic              xfer_half,
    output logic              xfer_done
);
    localparam int SIDES = 2;

    ctl_t              ctl_q;
    logic [ADDR_W-1:0] src_base, dst_base;
    logic [CNT_W-1:0]  count_base;
    logic              start, halt, busy, rd_req, wr_req, addr_load;
    logic              src_step, dst_step;
    logic [DW-1:0]     data_q;

    logic [ADDR_W-1:0] side_base  [SIDES];
    logic [ADDR_W-1:0] side_addr  [SIDES];
    logic              side_step  [SIDES];
    logic              side_fixed [SIDES];
    logic [1:0]        side_width [SIDES];

    pdma_regfile #(.AW(ADDR_W), .CW(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .busy(busy), .rdata(reg_rdata), .ctl(ctl_q),
        .src_base(src_base), .dst_base(dst_base), .count_base(count_base),
        .start(start), .halt(halt)
    );

    pdma_seq #(.CW(CNT_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .halt(halt),
        .cont(ctl_q.cont), .wait_log2(ctl_q.wait_log2),
        .dst_width(ctl_q.dst_width), .src_burst(ctl_q.src_burst),
        .dst_burst(ctl_q.dst_burst), .count_base(count_base),
        .src_req(src_req), .dst_req(dst_req), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .busy(busy), .rd_req(rd_req), .wr_req(wr_req),
        .addr_load(addr_load), .src_step(src_step), .dst_step(dst_step),
        .data_q(data_q), .xfer_half(xfer_half), .xfer_done(xfer_done)
    );

    // Side 0 is the source, side 1 the destination.
    assign side_base[0]  = src_base;
    assign side_base[1]  = dst_base;
    assign side_step[0]  = src_step;
    assign side_step[1]  = dst_step;
    assign side_fixed[0] = ctl_q.src_fixed;
    assign side_fixed[1] = ctl_q.dst_fixed;
    assign side_width[0] = ctl_q.src_width;
    assign side_width[1] = ctl_q.dst_width;

    for (genvar g = 0; g < SIDES; g++) begin : g_side
        pdma_addr_gen #(.AW(ADDR_W)) u_gen (
            .clk(clk), .rst_n(rst_n), .load(addr_load), .step(side_step[g]),
            .fixed(side_fixed[g]), .width_code(side_width[g]),
            .base(side_base[g]), .addr(side_addr[g])
        );
    end

    // Memory port: one access per cycle, the read side or the write side.
    assign mem_req   = rd_req || wr_req;
    assign mem_we    = wr_req;
    assign mem_addr  = wr_req ? side_addr[1] : side_addr[0];
    assign mem_size  = wr_req ? clean_code(ctl_q.dst_width) : clean_code(ctl_q.src_width);
    assign mem_wdata = data_q;
endmodule

// File: rtl/pdma_channel_chk.sv
// Property checker for the DMA channel, attached to every instance of the top.
module pdma_channel_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_req,
    input logic          mem_we,
    input logic          mem_ack,
    input logic [AW-1:0] mem_addr,
    input logic [1:0]    mem_size,
    input logic          xfer_half,
    input logic          xfer_done,
    input logic          busy,
    input logic          cont,
    input logic          src_fixed,
    input logic [AW-1:0] src_base
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req); // R5
    AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> $past(mem_req && mem_we && mem_ack)); // R11
    AST_DONE_CLEARS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && !cont) |-> !busy); // R11
    AST_HALF_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_half |-> $past(mem_req && mem_we && mem_ack)); // R12
    AST_SIZE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_size != 2'b11)); // R13
    AST_SRC_PINNED: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && src_fixed) |-> (mem_addr == src_base)); // R8
endmodule

bind pdma_channel pdma_channel_chk #(.AW(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
    .mem_ack(mem_ack), .mem_addr(mem_addr), .mem_size(mem_size),
    .xfer_half(xfer_half), .xfer_done(xfer_done), .busy(busy),
    .cont(ctl_q.cont), .src_fixed(ctl_q.src_fixed), .src_base(src_base)
);

// File: tb/sim_pdma_channel.sv
// Scoreboard bench: the driver predicts every destination write and its
// pulses; a monitor compares the writes, pulses and read spacing as they occur.
module sim_pdma_channel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        src_req = 1'b1, dst_req = 1'b1, ack_en = 1'b1;
    logic        mem_req, mem_we, mem_ack, xfer_half, xfer_done;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [1:0]  mem_size;

    int errors = 0, checks = 0, cyc = 0;
    int rd_count = 0, wr_count = 0, last_wr = -1, exp_gap = 1;
    logic pend_half = 1'b0, pend_done = 1'b0;
    string cur_tag = "R7";

    typedef struct {
        logic [31:0] addr;
        logic [1:0]  size;
        logic [31:0] data;
        logic        half;
        logic        done;
    } wr_item_t;
    wr_item_t exp_q[$];

    always #10 clk = ~clk;

    function automatic logic [31:0] pat(input logic [31:0] a);
        return {8'hA5, a[7:0] ^ 8'h3C, a[15:8], a[7:0]};
    endfunction

    function automatic logic [31:0] size_mask(input logic [1:0] s);
        return (s == 2'd0) ? 32'hFF : (s == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
    endfunction

    function automatic logic [31:0] mk_ctl(input logic cont, input logic [2:0] w,
            input logic [1:0] dw, input logic [1:0] db, input logic dfix,
            input logic [1:0] sw, input logic [1:0] sb, input logic sfix);
        return {1'b0, cont, w, dw, db, 1'b0, dfix, 5'd3, 5'd0, sw, sb, 1'b0, sfix, 5'd9};
    endfunction

    assign mem_ack   = mem_req & ack_en;
    assign mem_rdata = pat(mem_addr);

    pdma_channel u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_req(src_req),
        .dst_req(dst_req), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_size(mem_size), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .xfer_half(xfer_half),
        .xfer_done(xfer_done)
    );

    task automatic check(input logic ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a;
        #2;
        d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 3000; i++) begin
            reg_read(4'h0, v);
            if (!v[31]) break;
            @(posedge clk); #1;
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Scoreboard driver: predict one pass of destination writes.
    task automatic push_pass(input logic [31:0] s0, input logic [31:0] d0,
                             input int n, input logic [31:0] c);
        logic [1:0] sw, dw;
        int s, d, rem, thr, dec, db, sbytes;
        logic hd;
        wr_item_t it;
        sw = (c[10:9] == 2'd3) ? 2'd0 : c[10:9];
        dw = (c[26:25] == 2'd3) ? 2'd0 : c[26:25];
        sbytes = 1 << sw;
        db = 1 << dw;
        s = s0; d = d0; rem = n; thr = n / 2; hd = 1'b0;
        while (rem > 0) begin
            dec = (rem < db) ? rem : db;
            rem -= dec;
            it.addr = d; it.size = dw; it.data = pat(s);
            it.half = !hd && (rem <= thr);
            if (it.half) hd = 1'b1;
            it.done = (rem == 0);
            exp_q.push_back(it);
            if (!c[5])  s += sbytes;
            if (!c[21]) d += db;
        end
    endtask

    task automatic run_xfer(input logic [31:0] s, input logic [31:0] d,
                            input int n, input logic [31:0] c, input string tag);
        cur_tag = tag;
        reg_write(4'h4, s);
        reg_write(4'h8, d);
        reg_write(4'hC, n);
        push_pass(s, d, n, c);
        last_wr = -1;
        exp_gap = 1 << c[29:27];
        reg_write(4'h0, c | 32'h8000_0000);
        wait_idle();
        cycles(2);
        check(exp_q.size() == 0, {tag, " all writes seen"}, exp_q.size(), 0);
    endtask

    // Monitor: pulses, read spacing and write contents, away from the edge.
    always @(negedge clk) begin
        if (rst_n) begin
            wr_item_t it;
            cyc++;
            if (pend_half || xfer_half) check(xfer_half === pend_half, "R12 half pulse", xfer_half, pend_half);
            if (pend_done || xfer_done) check(xfer_done === pend_done, "R11 end pulse", xfer_done, pend_done);
            pend_half = 1'b0;
            pend_done = 1'b0;
            if (mem_req && mem_ack && !mem_we) begin
                rd_count++;
                if (last_wr >= 0 && exp_gap != 0)
                    check((cyc - last_wr) == exp_gap, "R10 read spacing", cyc - last_wr, exp_gap);
                last_wr = -1;
            end
            if (mem_req && mem_ack && mem_we) begin
                wr_count++;
                last_wr = cyc;
                if (exp_q.size() == 0) begin
                    check(1'b0, {cur_tag, " unexpected write"}, mem_addr, 0);
                end else begin
                    it = exp_q.pop_front();
                    check((mem_addr == it.addr) && (mem_size == it.size) &&
                          ((mem_wdata & size_mask(it.size)) == (it.data & size_mask(it.size))),
                          {cur_tag, " write addr/size/data"}, mem_addr, it.addr);
                    pend_half = it.half;
                    pend_done = it.done;
                end
            end
        end
    end

    // Watchdog: a hung run ends as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] v, c;
        int base;
        cycles(3);
        rst_n = 1'b1;
        cycles(1);

        // R1: reset values
        for (int i = 0; i < 4; i++) begin
            reg_read(4'(i * 4), v);
            check(v == 32'h0, "R1 reset readback", v, 0);
        end
        // R2 / R4: every field bit sticks; a start with zero count is ignored
        reg_write(4'h0, 32'hFFFF_FFFF);
        reg_read(4'h0, v);
        check(v == 32'h7FBF_07BF, "R2 R4 control readback", v, 32'h7FBF_07BF);
        reg_write(4'h0, 32'h0);
        // R3: count width; R1 address registers
        reg_write(4'hC, 32'hFFFF_FFFF);
        reg_read(4'hC, v);
        check(v == 32'h0003_FFFF, "R3 count mask", v, 32'h3FFFF);
        reg_write(4'h4, 32'h1234_5678);
        reg_read(4'h4, v);
        check(v == 32'h1234_5678, "R1 source readback", v, 32'h1234_5678);
        reg_write(4'h8, 32'h9ABC_DEF0);
        reg_read(4'h8, v);
        check(v == 32'h9ABC_DEF0, "R1 destination readback", v, 32'h9ABC_DEF0);

        // R7: byte copy, then mixed widths with a short last beat
        run_xfer(32'h100, 32'h200, 5, mk_ctl(0, 0, 0, 0, 0, 0, 0, 0), "R7 byte copy");
        run_xfer(32'h300, 32'h400, 6, mk_ctl(0, 0, 2, 0, 0, 1, 0, 0), "R7 mixed width");
        // R8: fixed source, then fixed destination
        run_xfer(32'h500, 32'h600, 3, mk_ctl(0, 0, 0, 0, 0, 2, 0, 1), "R8 fixed source");
        run_xfer(32'h700, 32'h800, 8, mk_ctl(0, 0, 1, 0, 1, 1, 0, 0), "R8 fixed destination");
        // R13: reserved codes behave as byte width and single beat
        run_xfer(32'h900, 32'hA00, 3, mk_ctl(0, 0, 3, 3, 0, 3, 3, 0), "R13 reserved codes");
        // R10: wait code 2 spaces the beats by four cycles
        run_xfer(32'hB00, 32'hC00, 3, mk_ctl(0, 2, 0, 0, 0, 0, 0, 0), "R10 wait states");

        // R9: one source request grants a four-beat burst
        c = mk_ctl(0, 0, 0, 0, 0, 0, 1, 0);
        cur_tag = "R9 burst";
        src_req = 1'b0;
        reg_write(4'h4, 32'hD00);
        reg_write(4'h8, 32'hE00);
        reg_write(4'hC, 8);
        push_pass(32'hD00, 32'hE00, 8, c);
        exp_gap = 0;
        base = rd_count;
        reg_write(4'h0, c | 32'h8000_0000);
        src_req = 1'b1;
        cycles(1);
        src_req = 1'b0;
        cycles(20);
        check(rd_count - base == 4, "R9 reads per request", rd_count - base, 4);
        reg_read(4'h0, v);
        check(v[31] == 1'b1, "R4 busy while active", v[31], 1);
        // R6: writes while busy leave everything unchanged
        reg_write(4'h4, 32'hDEAD_0000);
        reg_read(4'h4, v);
        check(v == 32'hD00, "R6 source write ignored", v, 32'hD00);
        reg_write(4'hC, 5);
        reg_read(4'hC, v);
        check(v == 8, "R6 count write ignored", v, 8);
        reg_write(4'h0, mk_ctl(1, 5, 2, 2, 1, 2, 2, 1) | 32'h8000_0000);
        reg_read(4'h0, v);
        check(v == (c | 32'h8000_0000), "R6 control fields frozen", v, c | 32'h8000_0000);
        src_req = 1'b1;
        wait_idle();
        cycles(2);
        check(exp_q.size() == 0, "R9 burst writes seen", exp_q.size(), 0);

        // R5: halt before any beat, then requests cause no access
        cur_tag = "R5 halt";
        src_req = 1'b0;
        exp_gap = 1;
        reg_write(4'hC, 4);
        base = rd_count;
        reg_write(4'h0, mk_ctl(0, 0, 0, 0, 0, 0, 0, 0) | 32'h8000_0000);
        reg_read(4'h0, v);
        check(v[31] == 1'b1, "R4 start sets busy", v[31], 1);
        reg_write(4'h0, 32'h0);
        reg_read(4'h0, v);
        check(v[31] == 1'b0, "R5 busy clears on halt", v[31], 0);
        src_req = 1'b1;
        cycles(10);
        check(rd_count == base, "R5 no reads after halt", rd_count - base, 0);

        // R11: continuous mode repeats the pass until halted
        c = mk_ctl(1, 0, 0, 0, 0, 0, 0, 0);
        cur_tag = "R11 continuous";
        reg_write(4'h4, 32'h40);
        reg_write(4'h8, 32'h80);
        reg_write(4'hC, 4);
        push_pass(32'h40, 32'h80, 4, c);
        push_pass(32'h40, 32'h80, 4, c);
        last_wr = -1;
        base = wr_count;
        reg_write(4'h0, c | 32'h8000_0000);
        for (int i = 0; i < 200; i++) begin
            if (wr_count >= base + 8) break;
            @(posedge clk); #1;
        end
        ack_en = 1'b0;
        reg_read(4'h0, v);
        check(v[31] == 1'b1, "R11 still busy after pass", v[31], 1);
        reg_write(4'h0, 32'h0);
        ack_en = 1'b1;
        cycles(10);
        check(wr_count - base == 8, "R11 two passes written", wr_count - base, 8);
        check(exp_q.size() == 0, "R11 all writes seen", exp_q.size(), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule